// File: doc/BRIEF.md
# Latency-Timed Speculative Wakeup Scheduler

This block is a small out-of-order issue window. Each slot holds one operation with two source tags, a ready flag per source, a destination tag, a load flag and, for non-loads, a fixed latency. An operation requests issue once both sources are ready. A fixed-priority selector picks one requester per cycle and reports it on the issue port.

Dependents are woken without waiting for results. When an operation issues, a timer in its slot starts. The destination tag is broadcast to every slot once the operation's latency has elapsed since issue. Every slot compares both of its sources against all broadcasts in that cycle.

Loads are assumed to hit, so their tag goes out two cycles after issue. A later hit report confirms the load and frees its slot. A miss report takes the readiness back from every source carrying that tag. Dependents that were already issued go back to waiting and their timers are cancelled. The load then broadcasts again eight cycles after its issue.

Top module: `ws_sched`

## Requirements
- R1: After reset, `iss_vld` is 0, every bit of `wk_vld` is 0 and `win_full` is 0.
- R2: A dispatch is written into the lowest-index free slot. `win_full` is 1 exactly in the cycles in which all 8 slots are allocated.
- R3: An operation dispatched with both sources ready is reported on `iss_vld` 2 cycles after its dispatch cycle. At most one operation issues per cycle, and among the requesting slots the lowest index wins. `iss_idx`, `iss_dst` and `iss_load` identify the issued slot.
- R4: A non-load with latency code c on `disp_lat` (2 bits, latency c+1, so 1 to 4 cycles) raises `wk_vld[slot]` with its tag on `wk_tag[slot*6 +: 6]` exactly c+1 cycles after its issue cycle.
- R5: A broadcast sets the ready flag of every matching source, and the waiting operation issues 2 cycles after the broadcast. A dispatch made in a broadcast cycle captures a match on its incoming sources in the same way.
- R6: A load (`disp_load`=1) broadcasts its tag 2 cycles after issue, before any report.
- R7: A hit report (`rpt_vld`=1, `rpt_hit`=1, `rpt_tag` = load tag) frees the load. The load does not broadcast again, and its dependents issue only once.
- R8: A miss report (`rpt_hit`=0) clears every source ready flag carrying that tag and returns issued dependents to waiting with no broadcast. The load broadcasts again 8 cycles after its issue, and its dependents then issue 2 cycles after that broadcast.
- R9: A slot is released in the cycle its final broadcast is driven, and a dispatch in that same cycle can use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld | input | 1 | Dispatch an operation this cycle |
| disp_load | input | 1 | Dispatched operation is a load |
| disp_lat | input | 2 | Non-load latency minus one |
| disp_src1 | input | 6 | First source tag |
| disp_rdy1 | input | 1 | First source already available |
| disp_src2 | input | 6 | Second source tag |
| disp_rdy2 | input | 1 | Second source already available |
| disp_dst | input | 6 | Destination tag |
| win_full | output | 1 | All slots allocated; do not dispatch |
| iss_vld | output | 1 | An operation issued this cycle |
| iss_idx | output | 3 | Slot of the issued operation |
| iss_dst | output | 6 | Destination tag of the issued operation |
| iss_load | output | 1 | Issued operation is a load |
| rpt_vld | input | 1 | Load outcome report valid |
| rpt_hit | input | 1 | 1 for hit, 0 for miss |
| rpt_tag | input | 6 | Destination tag of the reported load |
| wk_vld | output | 8 | Per-slot wakeup broadcast valid |
| wk_tag | output | 48 | Per-slot broadcast tags, slot i in bits 6i+5..6i |

## Verification
Each result has a fixed due cycle:
- an issue appears 2 cycles after a ready dispatch or after the waking broadcast;
- a non-load broadcast appears its latency after issue;
- a load broadcast appears 2 cycles after issue, and again 8 cycles after issue on a miss.

A behavioural model in the bench steps on each clock edge from the same inputs. Every output is compared with it in the middle of every cycle, so a result that comes one cycle early or late is caught in the cycle it goes wrong. The directed scenarios record the cycle of every issue and broadcast per tag. After each scenario has settled, the bench compares those cycles with the dispatch and report cycles plus the latencies stated in the requirements.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [1:0] {
    PH_FREE = 2'd0,
    PH_WAIT = 2'd1,
    PH_EXEC = 2'd2
  } phase_e;
endpackage

// File: rtl/ws_prio.sv
module ws_prio #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = i[IW-1:0];
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ws_match.sv
module ws_match #(
  parameter int N  = 8,
  parameter int TW = 6
) (
  input  logic [N-1:0]    bus_vld,
  input  logic [N*TW-1:0] bus_tag,
  input  logic [TW-1:0]   tag,
  output logic            hit
);
  always_comb begin
    hit = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (bus_vld[j] && (bus_tag[j*TW +: TW] == tag)) hit = 1'b1;
    end
  end
endmodule

// File: rtl/ws_entry.sv
module ws_entry
  import ws_pkg::*;
#(
  parameter int N        = 8,
  parameter int TW       = 6,
  parameter int LAT_W    = 3,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 8,
  localparam int CW      = $clog2(MISS_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             a_load,
  input  logic [LAT_W-1:0] a_lat,
  input  logic [TW-1:0]    a_s1,
  input  logic [TW-1:0]    a_s2,
  input  logic [1:0]       a_rdy,
  input  logic [TW-1:0]    a_dst,
  input  logic             grant,
  input  logic [N-1:0]     bus_vld,
  input  logic [N*TW-1:0]  bus_tag,
  input  logic             rpt_vld,
  input  logic             rpt_hit,
  input  logic [TW-1:0]    rpt_tag,
  output logic             busy,
  output logic             req,
  output logic             wake_q,
  output logic [TW-1:0]    dst_o,
  output logic             ld_o
);
  phase_e           ph;
  logic             ld_q;
  logic [LAT_W-1:0] lat_q;
  logic [TW-1:0]    s_q [2];
  logic [1:0]       r_q;
  logic             miss_q;
  logic [CW-1:0]    cnt_q;
  logic [TW-1:0]    dst_q;
  logic             wake_r;

  logic [1:0] hit_live;
  logic [1:0] kill;
  logic       kill_any, exec, own_rpt;
  logic       at_hit, at_miss, at_lat;
  logic       wake_d, free_d;

  for (genvar k = 0; k < 2; k++) begin : g_src
    ws_match #(.N(N), .TW(TW)) u_match (
      .bus_vld (bus_vld),
      .bus_tag (bus_tag),
      .tag     (s_q[k]),
      .hit     (hit_live[k])
    );
    assign kill[k] = rpt_vld && !rpt_hit && (ph != PH_FREE) && (s_q[k] == rpt_tag);
  end

  assign kill_any = |kill;
  assign exec     = (ph == PH_EXEC);
  assign req      = (ph == PH_WAIT) && (&r_q) && !kill_any;
  assign own_rpt  = rpt_vld && exec && ld_q && (dst_q == rpt_tag);
  assign at_hit   = (cnt_q == CW'(HIT_LAT));
  assign at_miss  = (cnt_q == CW'(MISS_LAT));
  assign at_lat   = (cnt_q == CW'(lat_q));

  always_comb begin
    wake_d = 1'b0;
    free_d = 1'b0;
    if (exec && !kill_any) begin
      if (ld_q) begin
        wake_d = at_hit || (at_miss && miss_q);
        free_d = at_miss || (own_rpt && rpt_hit);
      end else begin
        wake_d = at_lat;
        free_d = at_lat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_FREE;
      r_q    <= '0;
      miss_q <= 1'b0;
      cnt_q  <= '0;
      wake_r <= 1'b0;
    end else begin
      wake_r <= wake_d;
      if (alloc) begin
        ph     <= PH_WAIT;
        r_q    <= a_rdy;
        miss_q <= 1'b0;
        cnt_q  <= '0;
      end else if (ph != PH_FREE) begin
        r_q <= (r_q | hit_live) & ~kill;
        if (own_rpt && !rpt_hit) miss_q <= 1'b1;
        if (free_d) begin
          ph <= PH_FREE;
        end else if (kill_any && exec) begin
          ph    <= PH_WAIT;
          cnt_q <= '0;
        end else if (grant) begin
          ph    <= PH_EXEC;
          cnt_q <= CW'(1);
        end else if (exec && (cnt_q != '1)) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      ld_q   <= a_load;
      lat_q  <= a_lat;
      s_q[0] <= a_s1;
      s_q[1] <= a_s2;
      dst_q  <= a_dst;
    end
  end

  assign busy   = (ph != PH_FREE);
  assign wake_q = wake_r;
  assign dst_o  = dst_q;
  assign ld_o   = ld_q;

  p_grant_req_r3: assert property (@(posedge clk) disable iff (rst)
    grant |-> req);
  p_kill_blocks_grant_r8: assert property (@(posedge clk) disable iff (rst)
    kill_any |-> !grant);
  p_miss_only_load_r8: assert property (@(posedge clk) disable iff (rst)
    (miss_q && ph != PH_FREE) |-> ld_q);
  p_release_at_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (wake_r && !ld_q) |-> (ph == PH_FREE));
endmodule

// File: rtl/ws_sched.sv
module ws_sched #(
  parameter int N        = 8,
  parameter int TW       = 6,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 8,
  localparam int IW      = (N > 1) ? $clog2(N) : 1,
  localparam int LAT_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            disp_vld,
  input  logic            disp_load,
  input  logic [1:0]      disp_lat,
  input  logic [TW-1:0]   disp_src1,
  input  logic            disp_rdy1,
  input  logic [TW-1:0]   disp_src2,
  input  logic            disp_rdy2,
  input  logic [TW-1:0]   disp_dst,
  output logic            win_full,
  output logic            iss_vld,
  output logic [IW-1:0]   iss_idx,
  output logic [TW-1:0]   iss_dst,
  output logic            iss_load,
  input  logic            rpt_vld,
  input  logic            rpt_hit,
  input  logic [TW-1:0]   rpt_tag,
  output logic [N-1:0]    wk_vld,
  output logic [N*TW-1:0] wk_tag
);
  logic [N-1:0]  busy, req, gnt, alloc_oh;
  logic [N-1:0]  ld_a;
  logic [TW-1:0] dst_a [N];
  logic [IW-1:0] g_idx, a_idx;
  logic          g_any, a_any;
  logic          cap1, cap2;
  logic [1:0]    a_rdy;
  logic [LAT_W-1:0] a_lat;

  assign win_full = &busy;

  ws_prio #(.N(N)) u_sel (
    .req (req), .gnt (gnt), .idx (g_idx), .any (g_any)
  );

  logic [N-1:0] free_req, free_gnt;
  assign free_req = (disp_vld && !win_full) ? ~busy : '0;

  ws_prio #(.N(N)) u_alloc (
    .req (free_req), .gnt (free_gnt), .idx (a_idx), .any (a_any)
  );
  assign alloc_oh = a_any ? free_gnt : '0;

  ws_match #(.N(N), .TW(TW)) u_cap1 (
    .bus_vld (wk_vld), .bus_tag (wk_tag), .tag (disp_src1), .hit (cap1)
  );
  ws_match #(.N(N), .TW(TW)) u_cap2 (
    .bus_vld (wk_vld), .bus_tag (wk_tag), .tag (disp_src2), .hit (cap2)
  );

  assign a_rdy = {disp_rdy2 | cap2, disp_rdy1 | cap1};
  assign a_lat = LAT_W'(disp_lat) + LAT_W'(1);

  for (genvar i = 0; i < N; i++) begin : g_slot
    ws_entry #(
      .N(N), .TW(TW), .LAT_W(LAT_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
    ) u_entry (
      .clk     (clk),
      .rst     (rst),
      .alloc   (alloc_oh[i]),
      .a_load  (disp_load),
      .a_lat   (a_lat),
      .a_s1    (disp_src1),
      .a_s2    (disp_src2),
      .a_rdy   (a_rdy),
      .a_dst   (disp_dst),
      .grant   (gnt[i]),
      .bus_vld (wk_vld),
      .bus_tag (wk_tag),
      .rpt_vld (rpt_vld),
      .rpt_hit (rpt_hit),
      .rpt_tag (rpt_tag),
      .busy    (busy[i]),
      .req     (req[i]),
      .wake_q  (wk_vld[i]),
      .dst_o   (dst_a[i]),
      .ld_o    (ld_a[i])
    );
    assign wk_tag[i*TW +: TW] = dst_a[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld  <= 1'b0;
      iss_idx  <= '0;
      iss_dst  <= '0;
      iss_load <= 1'b0;
    end else begin
      iss_vld  <= g_any;
      iss_idx  <= g_idx;
      iss_dst  <= dst_a[g_idx];
      iss_load <= ld_a[g_idx];
    end
  end

  p_alloc_into_free_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_oh & busy) == '0);
  p_issued_slot_busy_r3: assert property (@(posedge clk) disable iff (rst)
    iss_vld |-> busy[iss_idx]);
endmodule

// File: tb/ws_sched_tb.sv
`timescale 1ns/1ps
module ws_sched_tb;
  localparam int N = 8;
  localparam int TW = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic disp_vld = 0, disp_load = 0, disp_rdy1 = 0, disp_rdy2 = 0;
  logic [1:0] disp_lat = 0;
  logic [TW-1:0] disp_src1 = 0, disp_src2 = 0, disp_dst = 0;
  logic rpt_vld = 0, rpt_hit = 0;
  logic [TW-1:0] rpt_tag = 0;
  logic win_full, iss_vld, iss_load;
  logic [2:0] iss_idx;
  logic [TW-1:0] iss_dst;
  logic [N-1:0] wk_vld;
  logic [N*TW-1:0] wk_tag;

  ws_sched u_dut (
    .clk(clk), .rst(rst), .disp_vld(disp_vld), .disp_load(disp_load),
    .disp_lat(disp_lat), .disp_src1(disp_src1), .disp_rdy1(disp_rdy1),
    .disp_src2(disp_src2), .disp_rdy2(disp_rdy2), .disp_dst(disp_dst),
    .win_full(win_full), .iss_vld(iss_vld), .iss_idx(iss_idx),
    .iss_dst(iss_dst), .iss_load(iss_load), .rpt_vld(rpt_vld),
    .rpt_hit(rpt_hit), .rpt_tag(rpt_tag), .wk_vld(wk_vld), .wk_tag(wk_tag)
  );

  int checks = 0, errors = 0, cyc = 0, full_n = 0;
  bit done = 0;
  int iss_n [64], iss_cyc [64], iss_at [64], wk_n [64], wk_cyc [64];

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 free, 1 waiting, 2 executing
  int mph [N], mlat [N], ms1 [N], ms2 [N], md [N], mcnt [N];
  bit ml [N], mr1 [N], mr2 [N], mmiss [N], mwk [N];
  bit miv, mil;
  int mii, mid;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < N; i++) begin mph[i] = 0; mwk[i] = 0; end
      miv = 0;
    end else begin
      bit h1 [N], h2 [N], k1 [N], k2 [N], kl [N], rq [N], wd [N], fd [N];
      bit own, dh1, dh2;
      int nsel, aslot;
      for (int i = 0; i < N; i++) begin
        h1[i] = 0; h2[i] = 0;
        for (int j = 0; j < N; j++) begin
          if (mwk[j] && md[j] == ms1[i]) h1[i] = 1;
          if (mwk[j] && md[j] == ms2[i]) h2[i] = 1;
        end
        k1[i] = mph[i] != 0 && rpt_vld && !rpt_hit && ms1[i] == rpt_tag;
        k2[i] = mph[i] != 0 && rpt_vld && !rpt_hit && ms2[i] == rpt_tag;
        kl[i] = k1[i] || k2[i];
        rq[i] = mph[i] == 1 && mr1[i] && mr2[i] && !kl[i];
        own = rpt_vld && mph[i] == 2 && ml[i] && md[i] == rpt_tag;
        wd[i] = mph[i] == 2 && !kl[i] &&
                (ml[i] ? (mcnt[i] == 2 || (mcnt[i] == 8 && mmiss[i])) : mcnt[i] == mlat[i]);
        fd[i] = mph[i] == 2 && !kl[i] &&
                (ml[i] ? (mcnt[i] == 8 || (own && rpt_hit)) : mcnt[i] == mlat[i]);
        if (own && !rpt_hit) mmiss[i] = 1;
      end
      nsel = -1; aslot = -1;
      for (int i = N - 1; i >= 0; i--) begin
        if (rq[i]) nsel = i;
        if (disp_vld && mph[i] == 0) aslot = i;
      end
      dh1 = 0; dh2 = 0;
      for (int j = 0; j < N; j++) begin
        if (mwk[j] && md[j] == disp_src1) dh1 = 1;
        if (mwk[j] && md[j] == disp_src2) dh2 = 1;
      end
      miv = nsel >= 0;
      if (miv) begin mii = nsel; mid = md[nsel]; mil = ml[nsel]; end
      for (int i = 0; i < N; i++) begin
        mwk[i] = wd[i];
        if (i == aslot) begin
          mph[i] = 1; ml[i] = disp_load; mlat[i] = disp_lat + 1;
          ms1[i] = disp_src1; ms2[i] = disp_src2; md[i] = disp_dst;
          mr1[i] = disp_rdy1 || dh1; mr2[i] = disp_rdy2 || dh2;
          mcnt[i] = 0; mmiss[i] = 0;
        end else if (mph[i] != 0) begin
          mr1[i] = (mr1[i] || h1[i]) && !k1[i];
          mr2[i] = (mr2[i] || h2[i]) && !k2[i];
          if (fd[i]) mph[i] = 0;
          else if (kl[i] && mph[i] == 2) begin mph[i] = 1; mcnt[i] = 0; end
          else if (i == nsel) begin mph[i] = 2; mcnt[i] = 1; end
          else if (mph[i] == 2 && mcnt[i] < 15) mcnt[i]++;
        end
      end
    end
  end

  // mid-cycle comparison and event recording
  always @(negedge clk) begin
    if (!rst) begin
      bit mfull;
      mfull = 1;
      for (int i = 0; i < N; i++) if (mph[i] == 0) mfull = 0;
      chk(win_full == mfull, "R2 full", int'(win_full), int'(mfull));
      chk(iss_vld == miv && (!miv || (iss_idx == mii && iss_dst == mid && iss_load == mil)),
          "R3 issue", miv ? int'(iss_dst) : int'(iss_vld), miv ? mid : 0);
      for (int i = 0; i < N; i++) begin
        if (wk_vld[i] != mwk[i] || (mwk[i] && wk_tag[i*TW +: TW] != md[i])) begin
          chk(0, "R4 wake", int'(wk_vld[i]), int'(mwk[i]));
        end
        if (wk_vld[i]) begin
          wk_n[wk_tag[i*TW +: TW]]++;
          wk_cyc[wk_tag[i*TW +: TW]] = cyc;
        end
      end
      if (iss_vld) begin
        iss_n[iss_dst]++; iss_cyc[iss_dst] = cyc; iss_at[iss_dst] = iss_idx;
      end
      if (win_full) full_n++;
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) tick();
  endtask

  task automatic disp(bit ld, int lat, int s1, bit r1, int s2, bit r2, int dst);
    disp_vld = 1; disp_load = ld; disp_lat = 2'(lat);
    disp_src1 = 6'(s1); disp_rdy1 = r1; disp_src2 = 6'(s2); disp_rdy2 = r2;
    disp_dst = 6'(dst);
    tick();
    disp_vld = 0;
  endtask

  task automatic report(bit hit, int tag, int at);
    wait_until(at);
    rpt_vld = 1; rpt_hit = hit; rpt_tag = 6'(tag);
    tick();
    rpt_vld = 0;
  endtask

  initial begin
    int d, il;
    for (int t = 0; t < 64; t++) begin iss_n[t] = 0; wk_n[t] = 0; end
    repeat (4) tick();
    rst = 0;
    tick();
    chk(iss_vld == 0, "R1 iss_vld", int'(iss_vld), 0);
    chk(wk_vld == 0, "R1 wk_vld", int'(wk_vld), 0);
    chk(win_full == 0, "R1 win_full", int'(win_full), 0);

    // chain through a latency-3 producer, dispatch capture, slot reuse
    d = cyc;
    disp(0, 2, 0, 1, 0, 1, 1);
    disp(0, 0, 1, 0, 0, 1, 2);
    disp(0, 0, 1, 0, 0, 1, 3);
    wait_until(d + 5);
    disp(0, 0, 1, 0, 0, 1, 4);
    wait_until(d + 16);
    chk(iss_cyc[1] == d + 2, "R3 ready dispatch", iss_cyc[1], d + 2);
    chk(wk_cyc[1] == d + 5, "R4 latency 3", wk_cyc[1], d + 5);
    chk(iss_cyc[4] == d + 7, "R5 capture at dispatch", iss_cyc[4], d + 7);
    chk(iss_at[4] == 0, "R9 slot reuse", iss_at[4], 0);
    chk(iss_cyc[2] == d + 8, "R3 priority second", iss_cyc[2], d + 8);
    chk(iss_cyc[3] == d + 9, "R3 priority third", iss_cyc[3], d + 9);
    chk(wk_cyc[2] == d + 9, "R4 latency 1", wk_cyc[2], d + 9);

    // load hit
    d = cyc; il = d + 2;
    disp(1, 0, 0, 1, 0, 1, 10);
    disp(0, 0, 10, 0, 0, 1, 11);
    report(1, 10, il + 3);
    wait_until(il + 14);
    chk(wk_cyc[10] == il + 2, "R6 speculative wake", wk_cyc[10], il + 2);
    chk(wk_n[10] == 1, "R7 single broadcast", wk_n[10], 1);
    chk(iss_n[11] == 1 && iss_cyc[11] == il + 4, "R7 dependent issue", iss_cyc[11], il + 4);

    // load miss after the dependent issued
    d = cyc; il = d + 2;
    disp(1, 0, 0, 1, 0, 1, 20);
    disp(0, 1, 20, 0, 0, 1, 21);
    report(0, 20, il + 4);
    wait_until(il + 16);
    chk(wk_n[20] == 2 && wk_cyc[20] == il + 8, "R8 rebroadcast", wk_cyc[20], il + 8);
    chk(iss_n[21] == 2 && iss_cyc[21] == il + 10, "R8 reissue", iss_cyc[21], il + 10);
    chk(wk_n[21] == 1 && wk_cyc[21] == il + 12, "R8 cancelled wake", wk_cyc[21], il + 12);

    // load miss in the speculative broadcast cycle
    d = cyc; il = d + 2;
    disp(1, 0, 0, 1, 0, 1, 30);
    disp(0, 0, 30, 0, 0, 1, 31);
    report(0, 30, il + 2);
    wait_until(il + 14);
    chk(iss_n[31] == 1 && iss_cyc[31] == il + 10, "R8 no early issue", iss_cyc[31], il + 10);

    // fill the window
    full_n = 0;
    d = cyc;
    disp(0, 3, 0, 1, 0, 1, 40);
    disp(0, 3, 40, 0, 0, 1, 41);
    for (int k = 0; k < 6; k++) disp(0, 0, 41, 0, 0, 1, 42 + k);
    disp(0, 0, 0, 1, 0, 1, 48);
    while (win_full) tick();
    disp(0, 0, 0, 1, 0, 1, 49);
    wait_until(d + 26);
    chk(full_n == 2, "R2 full cycles", full_n, 2);
    chk(iss_cyc[49] == d + 13, "R3 late dispatch wins", iss_cyc[49], d + 13);
    chk(iss_cyc[46] == d + 14 && iss_at[46] == 0, "R9 reused slot", iss_cyc[46], d + 14);
    chk(iss_cyc[47] == d + 19, "R3 highest slot last", iss_cyc[47], d + 19);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule